// File: doc/BRIEF.md
# Inter-Frame Gap Stretching Transmitter

This block sits on the transmit byte stream between a MAC and its coding layer. In wide-area mode it lengthens each inter-frame gap so that the long-run share of the line given to frames plus minimum gaps stays at 13/14. It counts frame bytes and minimum-gap bytes modulo 13. Each wrap of that count earns one extra idle byte. The earned idles are sent after the minimum gap that follows the next frame end. Because the minimum gap always goes out in full, a later layer that removes idle pairs still leaves at least the minimum gap.

The source offers bytes with a valid flag and a frame-end flag. The block takes them under a ready signal. Frame bytes pass through in the same cycle. Every cycle that carries no frame byte is an idle byte with code 0x07, marked by the idle flag. In local-area mode the gap is always the plain 12-byte minimum, and the counter and credit are held at zero.

Top module: `ifg_stretch_tx`

## Requirements
- R1: While `in_ready` is high, a byte accepted with `in_valid` shows up in the same cycle on `out_data` with `out_valid` high, and `out_last` equals `in_last`. `out_valid` and `out_idle` are never high together.
- R2: In wide-area mode, each accepted frame byte and each minimum-gap byte advances a modulo-13 count, and every wrap adds one credit byte. Stretch bytes and filler idles, sent while the source has nothing, are not counted.
- R3: After every frame end, exactly 12 minimum-gap idle bytes follow first, in either mode.
- R4: In wide-area mode the gap is 12 plus the credit held at the frame end. That credit includes a wrap caused by the last byte. The credit then clears, and the count remainder carries over.
- R5: `in_ready` stays low for the whole gap, minimum and stretch bytes alike. It returns high in the cycle right after the last gap byte.
- R6: In local-area mode the gap is exactly 12 bytes, and count and credit are held at zero. After a switch to wide-area mode, counting therefore starts from zero.
- R7: The credit saturates at CREDIT_MAX (default 15) and never wraps, however long the frame.
- R8: With back-to-back frames in wide-area mode, frame bytes plus minimum-gap bytes take no more than 13/14 of all cycles, apart from a bounded slack of one saturated credit.
- R9: Every cycle without a frame byte drives `out_idle` high and `out_data` to 0x07.
- R10: After reset, `in_ready` and `out_idle` are high, `out_valid` is low and the credit is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wan_mode | input | 1 | 1 = stretch gaps by earned credit, 0 = plain minimum gap |
| in_data | input | 8 | Source byte |
| in_valid | input | 1 | Source byte present |
| in_last | input | 1 | Source byte ends a frame |
| in_ready | output | 1 | Block accepts a source byte this cycle |
| out_data | output | 8 | Transmitted byte, frame data or idle code 0x07 |
| out_valid | output | 1 | Transmitted byte is frame data |
| out_last | output | 1 | Transmitted byte ends a frame |
| out_idle | output | 1 | Transmitted byte is an idle |

## Verification
On every cycle the assertions check several rules. A frame byte and an idle never share a cycle, and ready is low whenever a gap phase is active. Each frame end is followed by the minimum-gap phase and then by at least 12 idles before the next frame byte. Credit is earned only in wide-area mode and never by stretch bytes. A saturated credit stays put, and local-area mode clears it. The exact gap lengths cannot be seen from one cycle, so only the bench scenarios show them: the credit arithmetic across frames and the carried remainder, the fresh start after a mode switch, saturation on a long frame, and the long-run 13/14 bandwidth bound.

// File: rtl/ifgs_pkg.sv
package ifgs_pkg;
  // Transmit phase of the gap sequencer
  typedef enum logic [1:0] {
    PH_FRAME = 2'd0,   // accepting source bytes or sending filler idles
    PH_MIN   = 2'd1,   // minimum gap bytes (counted)
    PH_STR   = 2'd2    // stretch bytes (not counted)
  } phase_e;

  // Next value of a modulo counter
  function automatic int unsigned mod_step(input int unsigned v, input int unsigned div);
    return (v + 1 >= div) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/ifgs_credit.sv
module ifgs_credit #(
  parameter int DIV        = 13,
  parameter int CREDIT_MAX = 15,
  parameter int CW         = $clog2(CREDIT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wan_mode,
  input  logic          count_en,
  input  logic          take,
  output logic          wrap_ev,
  output logic [CW-1:0] credit_now,
  output logic [CW-1:0] credit_q
);
  import ifgs_pkg::*;
  localparam int CNTW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CNTW-1:0] cnt_q;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == CW'(CREDIT_MAX)) ? v : v + 1'b1;
  endfunction

  assign wrap_ev    = wan_mode && count_en && (cnt_q == CNTW'(DIV - 1));
  assign credit_now = wrap_ev ? sat_inc(credit_q) : credit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      credit_q <= '0;
    end else if (!wan_mode) begin
      cnt_q    <= '0;
      credit_q <= '0;
    end else begin
      if (count_en) cnt_q <= CNTW'(mod_step(int'(cnt_q), DIV));
      credit_q <= take ? '0 : credit_now;
    end
  end
endmodule

// File: rtl/ifgs_gap_seq.sv
module ifgs_gap_seq #(
  parameter int MIN_GAP    = 12,
  parameter int CREDIT_MAX = 15,
  parameter int CW         = $clog2(CREDIT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  logic [CW-1:0]     stretch_len,
  output ifgs_pkg::phase_e  phase,
  output logic              gap_min_active,
  output logic              gap_str_active
);
  import ifgs_pkg::*;
  localparam int MAXV = (MIN_GAP > CREDIT_MAX) ? MIN_GAP : CREDIT_MAX;
  localparam int RW   = $clog2(MAXV + 1);

  phase_e        ph_q;
  logic [RW-1:0] rem_q;
  logic [CW-1:0] str_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_FRAME;
      rem_q <= '0;
      str_q <= '0;
    end else begin
      unique case (ph_q)
        PH_FRAME: if (frame_end) begin
          ph_q  <= PH_MIN;
          rem_q <= RW'(MIN_GAP - 1);
          str_q <= stretch_len;
        end
        PH_MIN: if (rem_q == '0) begin
          if (str_q != '0) begin
            ph_q  <= PH_STR;
            rem_q <= RW'(str_q) - 1'b1;
          end else begin
            ph_q  <= PH_FRAME;
          end
        end else begin
          rem_q <= rem_q - 1'b1;
        end
        PH_STR: if (rem_q == '0) ph_q <= PH_FRAME;
                else rem_q <= rem_q - 1'b1;
        default: ph_q <= PH_FRAME;
      endcase
    end
  end

  assign phase          = ph_q;
  assign gap_min_active = (ph_q == PH_MIN);
  assign gap_str_active = (ph_q == PH_STR);
endmodule

// File: rtl/ifg_stretch_tx.sv
module ifg_stretch_tx #(
  parameter int          DW         = 8,
  parameter int          MIN_GAP    = 12,
  parameter int          DIV        = 13,
  parameter int          CREDIT_MAX = 15,
  parameter logic [7:0]  IDLE_BYTE  = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wan_mode,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  input  logic          in_last,
  output logic          in_ready,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          out_last,
  output logic          out_idle
);
  import ifgs_pkg::*;
  localparam int CW = $clog2(CREDIT_MAX + 1);

  // Named internal events, visible to the bound checker
  phase_e        phase;
  logic          gap_min_active, gap_str_active;
  logic          accept, frame_end, count_en, wrap_ev;
  logic [CW-1:0] credit_now, credit_q, stretch_len;

  assign in_ready    = (phase == PH_FRAME);
  assign accept      = in_valid && in_ready;
  assign frame_end   = accept && in_last;
  assign count_en    = accept || gap_min_active;
  assign stretch_len = wan_mode ? credit_now : '0;

  ifgs_credit #(.DIV(DIV), .CREDIT_MAX(CREDIT_MAX), .CW(CW)) u_credit (
    .clk(clk), .rst_n(rst_n), .wan_mode(wan_mode), .count_en(count_en),
    .take(frame_end), .wrap_ev(wrap_ev), .credit_now(credit_now), .credit_q(credit_q)
  );

  ifgs_gap_seq #(.MIN_GAP(MIN_GAP), .CREDIT_MAX(CREDIT_MAX), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .stretch_len(stretch_len),
    .phase(phase), .gap_min_active(gap_min_active), .gap_str_active(gap_str_active)
  );

  assign out_valid = accept;
  assign out_last  = frame_end;
  assign out_idle  = !accept;
  assign out_data  = accept ? in_data : DW'(IDLE_BYTE);
endmodule

// File: rtl/ifgs_checker.sv
module ifgs_checker #(
  parameter int MIN_GAP    = 12,
  parameter int CREDIT_MAX = 15,
  parameter int CW         = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wan_mode,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_last,
  input logic          out_idle,
  input logic          wrap_ev,
  input logic [CW-1:0] credit_q,
  input logic          gap_min_active,
  input logic          gap_str_active
);
  logic       after_end;
  logic [7:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      after_end <= 1'b0;
      idle_cnt  <= '0;
    end else begin
      if (out_valid) after_end <= out_last;
      if (out_valid && out_last) idle_cnt <= '0;
      else if (out_idle && idle_cnt != 8'hFF) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_idle));
  p_ready_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_min_active || gap_str_active) |-> !in_ready);
  p_end_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |=> gap_min_active);
  p_min_idles_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && after_end) |-> (idle_cnt >= 8'(MIN_GAP)));
  p_wrap_wan_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |-> wan_mode);
  p_str_uncounted_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gap_str_active |-> !wrap_ev);
  p_lan_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wan_mode |=> (credit_q == '0));
  p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wan_mode && credit_q == CW'(CREDIT_MAX) && !(out_valid && out_last)) |=> (credit_q == CW'(CREDIT_MAX)));
endmodule

bind ifg_stretch_tx ifgs_checker #(.MIN_GAP(MIN_GAP), .CREDIT_MAX(CREDIT_MAX), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wan_mode(wan_mode), .in_ready(in_ready),
  .out_valid(out_valid), .out_last(out_last), .out_idle(out_idle),
  .wrap_ev(wrap_ev), .credit_q(credit_q),
  .gap_min_active(gap_min_active), .gap_str_active(gap_str_active)
);

// File: tb/sim_ifg_stretch_tx.sv
module sim_ifg_stretch_tx;
  localparam int CLK_P = 10;
  localparam int MAXC  = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wan_mode = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0, in_last = 1'b0;
  logic       in_ready, out_valid, out_last, out_idle;
  logic [7:0] out_data;

  int n_chk = 0, n_fail = 0;
  int m_cnt = 0, m_cred = 0;          // bench model of the count and credit
  int s_counted = 0, s_cycles = 0;    // bandwidth statistics
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ifg_stretch_tx u0 (
    .clk(clk), .rst_n(rst_n), .wan_mode(wan_mode), .in_data(in_data),
    .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_last(out_last), .out_idle(out_idle)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int cap(input int v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  // Sends one frame and measures the gap after it; returns the gap length
  task automatic run_frame(input int len, input string req, output int gap);
    int exp_gap, tot, bad_pass, bad_idle;
    if (wan_mode) begin
      tot = m_cnt + len;
      m_cred = cap(m_cred + tot / 13);
      m_cnt = tot % 13;
      exp_gap = 12 + m_cred;
      tot = m_cnt + 12;
      m_cred = cap(tot / 13);
      m_cnt = tot % 13;
    end else begin
      exp_gap = 12; m_cnt = 0; m_cred = 0;
    end
    bad_pass = 0; bad_idle = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'(i * 7 + len); in_last = (i == len - 1);
      #1;
      if (!(in_ready && out_valid && !out_idle && out_data == in_data && out_last == in_last))
        bad_pass++;
    end
    chk(bad_pass == 0, "R1", "pass-through mismatches", bad_pass, 0);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    gap = 0;
    forever begin
      #1;
      if (in_ready) break;
      if (!(out_idle && !out_valid && out_data == 8'h07)) bad_idle++;
      gap++;
      @(negedge clk);
    end
    chk(bad_idle == 0, "R9", "gap bytes not idle 0x07", bad_idle, 0);
    chk(out_idle && !out_valid && out_data == 8'h07, "R9", "filler idle", int'(out_data), 7);
    chk(gap == exp_gap, req, $sformatf("gap after %0d-byte frame", len), gap, exp_gap);
    if (wan_mode) begin
      s_counted += len + 12;
      s_cycles  += len + gap + 1;
    end
  endtask

  task automatic t_reset;
    chk(in_ready && out_idle && !out_valid && out_data == 8'h07, "R10", "reset outputs",
        {in_ready, out_idle, out_valid}, 3'b110);
  endtask

  task automatic t_lan;
    int g;
    wan_mode = 1'b0;
    run_frame(50, "R6", g);
    run_frame(1, "R3", g);
    run_frame(400, "R6", g);
  endtask

  task automatic t_wan_credit;
    int g;
    @(negedge clk); wan_mode = 1'b0; m_cnt = 0; m_cred = 0;
    @(negedge clk); wan_mode = 1'b1;
    run_frame(13, "R6", g);    // fresh start: one wrap exactly on the last byte
    run_frame(20, "R4", g);
    run_frame(20, "R2", g);
    run_frame(1, "R4", g);
    run_frame(12, "R2", g);
    run_frame(64, "R5", g);
  endtask

  task automatic t_saturate;
    int g;
    run_frame(300, "R7", g);
    chk(g == 12 + MAXC, "R7", "saturated stretch", g, 12 + MAXC);
    run_frame(13, "R4", g);
  endtask

  task automatic t_bandwidth;
    int g;
    @(negedge clk); wan_mode = 1'b0; m_cnt = 0; m_cred = 0;
    @(negedge clk); wan_mode = 1'b1;
    s_counted = 0; s_cycles = 0;
    for (int k = 0; k < 12; k++) run_frame(64 + k * 9, "R4", g);
    chk(s_counted * 14 <= s_cycles * 13 + 14 * MAXC, "R8", "counted*14 vs cycles*13",
        s_counted * 14, s_cycles * 13);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 3);
    @(negedge clk); rst_n = 1'b1;
    #1;
    t_reset();
    t_lan();
    t_wan_credit();
    t_saturate();
    t_bandwidth();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule